// File: doc/BRIEF.md
# I2C Register-Addressed Block Read Master

This block is a bit-level I2C master that fetches a run of bytes from a register inside a target device. The host presents a 7-bit target address, a one-byte register selector and a byte count, then pulses `start`. The engine issues a start condition and the address with the write bit. It sends the register selector and then re-addresses the target with a repeated start, with no stop between the two phases. It sends the address with the read bit and clocks in the requested number of bytes. Each byte received is handed to the host as a one-cycle valid strobe with the byte beside it.

The master acknowledges every received byte except the last, which gets a NOT-acknowledge followed by a stop. A high acknowledge slot from the target during any of the three bytes the master sends aborts the transfer with a stop and a device-error flag. SCL and SDA are driven as open-drain pull-down enables. A programmable divider sets the SCL half-period in system clocks. Clock stretching, arbitration and multi-master operation are not supported.

Top module: `i2c_blkrd_master`

## Requirements
- R1: On an accepted `start`, SDA is pulled low while SCL is released (start condition). The first byte sent is `{tgt_addr, 0}`, MSB first.
- R2: After the target acknowledges the address byte, the master sends the register selector latched at `start`, MSB first, and samples a target acknowledge.
- R3: After the register byte's acknowledge, a repeated start follows directly. A complete read contains exactly two start conditions and exactly one stop condition.
- R4: After the repeated start, the master sends `{tgt_addr, 1}` and samples a target acknowledge.
- R5: Data bytes are received MSB first. Each byte appears on `rx_byte` with a one-cycle `rx_valid` strobe, in bus order, and exactly `byte_cnt` strobes occur per successful read.
- R6: The master drives SDA low in the acknowledge slot after every data byte except the last. It leaves SDA released after the last byte and then issues a stop.
- R7: If any target acknowledge slot is sampled high, the master issues a stop and ends with `done` and `dev_err` set. No `rx_valid` strobe occurs in that transfer.
- R8: A `start` with `byte_cnt` of 0 or above 32 is rejected. `done` and `cnt_err` are high one cycle later, `busy` stays low, and neither bus line is pulled.
- R9: SDA changes while SCL is released only for a start, a repeated start or a stop condition.
- R10: Every SCL low period during a transfer lasts max(`half_div`, 2) system clocks.
- R11: After reset and whenever `busy` is low, neither bus line is pulled.
- R12: `done` is a single-cycle pulse with `busy` low. `dev_err` and `cnt_err` hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (accepted while idle) |
| tgt_addr | input | 7 | Target device address |
| reg_sel | input | 8 | Register selector sent in the write phase |
| byte_cnt | input | CNT_W (6) | Number of bytes to read, 1 to 32 |
| half_div | input | DIV_W (16) | SCL half-period in system clocks (minimum 2) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| dev_err | output | 1 | Target did not acknowledge |
| cnt_err | output | 1 | Byte count rejected |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |

## Verification
A rejected count produces `done` and `cnt_err` on the cycle after the edge that sees `start`. The bench therefore drives `start` on one falling clock edge and checks on the next falling edge. Bus results arrive at the pace of the divider: an `rx_valid` strobe follows the SCL high phase of each byte's eighth bit, and `done` comes one half-period after the stop edge. For these, a behavioural target follows the wire levels, a monitor pops expected bytes from a scoreboard queue on each strobe, and the transfer checks run only on the falling edge where `done` is seen. SCL low-run lengths are measured cycle by cycle and compared with the clamped divider value.

// File: rtl/i2c_blkrd_pkg.sv
package i2c_blkrd_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_LOW,
        PH_HIGH,
        PH_RS_A,
        PH_RS_B,
        PH_RS_C,
        PH_STOP_A,
        PH_STOP_B,
        PH_STOP_C
    } phase_e;

    typedef enum logic [1:0] {
        KD_ADDR_W,
        KD_REG,
        KD_ADDR_R,
        KD_DATA
    } kind_e;

    localparam logic [3:0] ACK_SLOT = 4'd8;

endpackage

// File: rtl/i2c_blkrd_sync.sv
module i2c_blkrd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_blkrd_tick.sv
module i2c_blkrd_tick #(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff   = (half_div < FLOOR) ? FLOOR : half_div;
        tick  = run && (cnt_q == eff - 1'b1);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_blkrd_seq.sv
module i2c_blkrd_seq
    import i2c_blkrd_pkg::*;
#(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MAX_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [6:0]       tgt_addr,
    input  logic [7:0]       reg_sel,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             sda_s,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             dev_err,
    output logic             cnt_err,
    output logic             rx_valid,
    output logic [7:0]       rx_byte,
    output logic             edge_ok
);
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        kind_e            kind;
        logic [3:0]       bit_idx;
        logic [7:0]       shreg;
        logic [6:0]       addr;
        logic [7:0]       regv;
        logic [CNT_W-1:0] left;
        logic             sda_oe;
        logic             done;
        logic             rx_valid;
        logic             dev_err;
        logic             cnt_err;
    } seq_t;

    seq_t d, q;
    logic len_bad;
    logic drive_now;

    always_comb begin
        len_bad = (byte_cnt == '0) || (byte_cnt > LEN_MAX);

        // Pull level for the current phase; registered so SDA moves one
        // clock after SCL falls.
        case (q.ph)
            PH_START, PH_RS_C, PH_STOP_A, PH_STOP_B: drive_now = 1'b1;
            PH_LOW, PH_HIGH: begin
                if (q.kind == KD_DATA) drive_now = (q.bit_idx == ACK_SLOT) && (q.left != ONE);
                else                   drive_now = (q.bit_idx != ACK_SLOT) && !q.shreg[7];
            end
            default: drive_now = 1'b0;
        endcase

        d          = q;
        d.done     = 1'b0;
        d.rx_valid = 1'b0;
        d.sda_oe   = drive_now;

        if (q.ph == PH_IDLE) begin
            if (start) begin
                if (len_bad) begin
                    d.cnt_err = 1'b1;
                    d.dev_err = 1'b0;
                    d.done    = 1'b1;
                end else begin
                    d.ph      = PH_START;
                    d.kind    = KD_ADDR_W;
                    d.addr    = tgt_addr;
                    d.regv    = reg_sel;
                    d.shreg   = {tgt_addr, 1'b0};
                    d.bit_idx = '0;
                    d.left    = byte_cnt;
                    d.cnt_err = 1'b0;
                    d.dev_err = 1'b0;
                end
            end
        end else if (tick) begin
            case (q.ph)
                PH_START: d.ph = PH_LOW;
                PH_LOW:   d.ph = PH_HIGH;
                PH_HIGH: begin
                    d.ph = PH_LOW;
                    if (q.bit_idx != ACK_SLOT) begin
                        d.bit_idx = q.bit_idx + 1'b1;
                        d.shreg   = {q.shreg[6:0], (q.kind == KD_DATA) ? sda_s : 1'b0};
                        if (q.kind == KD_DATA && q.bit_idx == 4'd7) d.rx_valid = 1'b1;
                    end else begin
                        d.bit_idx = '0;
                        if (q.kind == KD_DATA) begin
                            if (q.left == ONE) d.ph = PH_STOP_A;
                            else               d.left = q.left - 1'b1;
                        end else if (sda_s) begin
                            d.dev_err = 1'b1;
                            d.ph      = PH_STOP_A;
                        end else begin
                            case (q.kind)
                                KD_ADDR_W: begin
                                    d.kind  = KD_REG;
                                    d.shreg = q.regv;
                                end
                                KD_REG:  d.ph   = PH_RS_A;
                                default: d.kind = KD_DATA;
                            endcase
                        end
                    end
                end
                PH_RS_A: d.ph = PH_RS_B;
                PH_RS_B: d.ph = PH_RS_C;
                PH_RS_C: begin
                    d.ph      = PH_LOW;
                    d.kind    = KD_ADDR_R;
                    d.shreg   = {q.addr, 1'b1};
                    d.bit_idx = '0;
                end
                PH_STOP_A: d.ph = PH_STOP_B;
                PH_STOP_B: d.ph = PH_STOP_C;
                PH_STOP_C: begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= PH_IDLE;
            q.kind    <= KD_ADDR_W;
        end else begin
            q <= d;
        end
    end

    assign scl_oe   = (q.ph == PH_LOW) || (q.ph == PH_RS_A) || (q.ph == PH_STOP_A);
    assign sda_oe   = q.sda_oe;
    assign busy     = (q.ph != PH_IDLE);
    assign done     = q.done;
    assign dev_err  = q.dev_err;
    assign cnt_err  = q.cnt_err;
    assign rx_valid = q.rx_valid;
    assign rx_byte  = q.shreg;
    assign edge_ok  = (q.ph == PH_START) || (q.ph == PH_RS_C) || (q.ph == PH_STOP_C);
endmodule

// File: rtl/i2c_blkrd_master.sv
module i2c_blkrd_master #(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned MAX_LEN     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       tgt_addr,
    input  logic [7:0]       reg_sel,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [DIV_W-1:0] half_div,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             dev_err,
    output logic             cnt_err,
    output logic             rx_valid,
    output logic [7:0]       rx_byte
);
    localparam int unsigned MIN_HALF = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic sda_s;
    logic tick;
    logic edge_ok;

    i2c_blkrd_sync #(.STAGES(MIN_HALF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_s)
    );

    i2c_blkrd_tick #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_div (half_div),
        .tick     (tick)
    );

    i2c_blkrd_seq #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .tgt_addr (tgt_addr),
        .reg_sel  (reg_sel),
        .byte_cnt (byte_cnt),
        .sda_s    (sda_s),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .done     (done),
        .dev_err  (dev_err),
        .cnt_err  (cnt_err),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .edge_ok  (edge_ok)
    );
endmodule

// File: rtl/i2c_blkrd_chk.sv
module i2c_blkrd_chk #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MAX_LEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             busy,
    input logic             done,
    input logic             cnt_err,
    input logic             rx_valid,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             edge_ok
);
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_LEN);

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R9
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> edge_ok);

    // R8
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((byte_cnt == '0) || (byte_cnt > LEN_MAX))) |=> (done && cnt_err && !busy));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R5
    rx_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);
endmodule

bind i2c_blkrd_master i2c_blkrd_chk #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byte_cnt (byte_cnt),
    .busy     (busy),
    .done     (done),
    .cnt_err  (cnt_err),
    .rx_valid (rx_valid),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .edge_ok  (edge_ok)
);

// File: tb/i2c_blkrd_master_bench.sv
`timescale 1ns/1ps
module i2c_blkrd_master_bench;
    localparam logic [6:0] SLV = 7'h52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  tgt_addr = '0;
    logic [7:0]  reg_sel = '0;
    logic [5:0]  byte_cnt = '0;
    logic [15:0] half_div = 16'd4;
    logic        scl_oe, sda_oe, busy, done, dev_err, cnt_err, rx_valid;
    logic [7:0]  rx_byte;
    logic        s_drive = 1'b0;
    wire         scl_line = !scl_oe;
    wire         sda_line = !(sda_oe || s_drive);

    always #4 clk = ~clk;

    i2c_blkrd_master u_i2c_blkrd_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
        .reg_sel(reg_sel), .byte_cnt(byte_cnt), .half_div(half_div),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .dev_err(dev_err), .cnt_err(cnt_err),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] pat(logic [7:0] r, int k);
        return (r + 8'(k * 29)) ^ 8'h5A;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural target ----------------
    int bitc = 0, mode = 0, starts = 0, stops = 0, kidx = 0;
    int s_acks = 0, s_naks = 0;
    logic [7:0] sh = '0, regp = '0, a0 = '0, a1 = '0;
    logic matched = 1'b0, rw = 1'b0, last_ack = 1'b0, nack_reg = 1'b0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        starts++; mode = 1; bitc = 0; s_drive = 1'b0;
    end

    always @(posedge sda_line) if (scl_line === 1'b1) begin
        stops++; mode = 0; s_drive = 1'b0;
    end

    always @(posedge scl_line) begin
        if (mode == 1 || mode == 2) begin
            if (bitc < 8) sh = {sh[6:0], sda_line};
            bitc++;
        end else if (mode == 4) begin
            if (bitc == 8) begin
                last_ack = (sda_line === 1'b0);
                if (last_ack) s_acks++; else s_naks++;
            end
            bitc++;
        end
    end

    always @(negedge scl_line) begin
        logic [7:0] tb;
        if (bitc == 9) begin
            bitc = 0;
            case (mode)
                1: begin mode = !matched ? 0 : (rw ? 4 : 2); kidx = 0; end
                2: mode = 3;
                4: if (last_ack) kidx++; else mode = 0;
                default: ;
            endcase
        end
        s_drive = 1'b0;
        case (mode)
            1: if (bitc == 8) begin
                if (starts == 1) a0 = sh; else a1 = sh;
                matched = (sh[7:1] == SLV);
                rw      = sh[0];
                s_drive = matched;
            end
            2: if (bitc == 8) begin
                regp    = sh;
                s_drive = !nack_reg;
            end
            4: if (bitc < 8) begin
                tb      = pat(regp, kidx);
                s_drive = !tb[7 - bitc];
            end
            default: ;
        endcase
    end

    // ---------------- scoreboard monitor ----------------
    logic [7:0] exp_q[$];
    int rx_seen = 0, run_len = 0, bad_half = 0, exp_half = 2;

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_seen++;
            if (exp_q.size() == 0) chk("R5 unexpected byte", {24'd0, rx_byte}, 32'hFFFF);
            else chk("R5 byte order", {24'd0, rx_byte}, {24'd0, exp_q.pop_front()});
        end
        if (busy && scl_oe) run_len++;
        else if (run_len != 0) begin
            if (run_len != exp_half) bad_half++;
            run_len = 0;
        end
    end

    // ---------------- driver ----------------
    task automatic do_read(logic [6:0] a, logic [7:0] r, logic [5:0] n,
                           logic [15:0] dv, logic exp_err);
        tgt_addr = a; reg_sel = r; byte_cnt = n; half_div = dv;
        exp_half = (dv < 2) ? 2 : int'(dv);
        starts = 0; stops = 0; s_acks = 0; s_naks = 0;
        rx_seen = 0; bad_half = 0; a0 = '0; a1 = '0;
        if (!exp_err) for (int k = 0; k < int'(n); k++) exp_q.push_back(pat(r, k));
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        chk("R12 busy low at done", {31'd0, busy}, 32'd0);
        chk("R7 dev_err", {31'd0, dev_err}, {31'd0, exp_err});
        chk("R12 cnt_err clear", {31'd0, cnt_err}, 32'd0);
        chk("R11 bus released", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R1 first byte", {24'd0, a0}, {24'd0, a, 1'b0});
        chk("R10 low period", bad_half, 0);
        if (!exp_err) begin
            chk("R2 register byte", {24'd0, regp}, {24'd0, r});
            chk("R3 R9 start count", starts, 2);
            chk("R3 R9 stop count", stops, 1);
            chk("R4 read address byte", {24'd0, a1}, {24'd0, a, 1'b1});
            chk("R5 byte count", rx_seen, int'(n));
            chk("R5 queue drained", exp_q.size(), 0);
            chk("R6 master acks", s_acks, int'(n) - 1);
            chk("R6 final nack", s_naks, 1);
        end else begin
            chk("R7 no bytes", rx_seen, 0);
            chk("R7 stop issued", stops, 1);
            chk("R9 single start", starts, 1);
        end
        @(negedge clk);
        chk("R12 done pulse", {31'd0, done}, 32'd0);
        exp_q.delete();
    endtask

    task automatic bad_len(logic [5:0] n);
        byte_cnt = n; starts = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R8 done next cycle", {31'd0, done}, 32'd1);
        chk("R8 cnt_err", {31'd0, cnt_err}, 32'd1);
        chk("R8 not busy", {31'd0, busy}, 32'd0);
        chk("R8 no pull", {30'd0, scl_oe, sda_oe}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R8 no bus activity", starts, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset lines", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        chk("R11 reset rx_valid", {31'd0, rx_valid}, 32'd0);
        bad_len(6'd0);
        bad_len(6'd40);
        do_read(SLV, 8'h10, 6'd1, 16'd4, 1'b0);
        chk("R12 cnt_err cleared by start", {31'd0, cnt_err}, 32'd0);
        do_read(SLV, 8'hC3, 6'd5, 16'd3, 1'b0);
        do_read(SLV, 8'h7E, 6'd32, 16'd1, 1'b0);
        do_read(7'h11, 8'h20, 6'd4, 16'd2, 1'b0 | 1'b1);
        nack_reg = 1'b1;
        do_read(SLV, 8'h21, 6'd3, 16'd2, 1'b1);
        nack_reg = 1'b0;
        do_read(SLV, 8'h00, 6'd2, 16'd5, 1'b0);
        chk("R12 dev_err cleared", {31'd0, dev_err}, 32'd0);
        finish_run();
    end
endmodule